// File: doc/BRIEF.md
# Low-Speed Oscillator Enable Controller

This block gives software control over an external 32 kHz low-speed oscillator through a single 32-bit control word. Software turns the oscillator on or off with an enable bit. It can also choose bypass mode, where an external clock is fed in place of a crystal. A ready flag, maintained entirely by hardware, tells software when the oscillator clock can be used.

Ready is produced in the oscillator clock domain. After enable is set and the oscillator reports itself stable, a stabilization count runs. The count is long in crystal mode and short in bypass mode. After enable is cleared, ready falls a fixed number of oscillator cycles later. Setting enable again inside that window cancels the fall. The enable and bypass bits cross into the oscillator domain, and ready crosses back to the system clock, through two-flop synchronizers.

The register port is a request/ready handshake with per-byte lane enables. An access that directly follows the completion of another access is held off by a configurable number of wait states. An isolated access completes in the cycle it is requested.

Top module: `losc_ctrl`

## Requirements
- R1: After reset, `oscEn`, `oscBypass` and `oscReady` are 0, and the control word reads as 0.
- R2: A completed write with lane 0 enabled loads data bit 0 into the enable bit, which drives `oscEn` directly.
- R3: Writes whose lane-0 enable (`regBe[0]`) is 0 change nothing. Data bit 1 of any write is ignored. Bits 31:3 of the read data are always 0.
- R4: Data bit 2 loads the bypass bit, which drives `oscBypass`, only if the enable bit is 0 before the write. Otherwise the bypass bit keeps its value, even when the same write clears enable.
- R5: With `oscStable` held high, the oscillator-domain ready rises on the START_CYCLES+3rd oscillator rising edge after the write that sets enable. In bypass mode the count is BYPASS_CYCLES+3.
- R6: The oscillator-domain ready falls on the FALL_CYCLES-th (default 6) oscillator rising edge after the write that clears enable.
- R7: If enable is written to 1 again within the first 3 oscillator edges after a disable write, ready never falls. A re-enable after the 4th edge does not stop the fall.
- R8: While `oscStable` is low, ready stays 0 and no count runs. When it rises between oscillator edges with enable on, ready rises on the START_CYCLES+1st following oscillator edge.
- R9: An access requested in the cycle right after a completed access gets WAIT_STATES (0..3) wait cycles before `regReady`. Any other access completes with no wait. `regReady` is never high without `regReq`.
- R10: The read data bit 0 is enable, bit 1 is ready (system-clock synchronized `oscReady`) and bit 2 is bypass. The synchronized `oscReady` follows the oscillator-domain ready after two system clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sysClk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset for both domains |
| oscClk | input | 1 | Low-speed oscillator clock |
| oscStable | input | 1 | Oscillator stable indication, synchronous to oscClk |
| regReq | input | 1 | Register access request, held until regReady |
| regWrite | input | 1 | 1 for write, 0 for read |
| regBe | input | 4 | Byte lane enables |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data |
| regReady | output | 1 | Access completes in this cycle |
| oscEn | output | 1 | Oscillator enable |
| oscBypass | output | 1 | Bypass select |
| oscReady | output | 1 | Ready, synchronized to sysClk |

## Verification
The assertions assume the following about the inputs. `regReq` stays high with stable controls until `regReady` answers it. `oscStable` changes only between oscillator edges. The two clocks never share an edge, so every crossing resolves the same way in every run. The stimulus meets these conditions in three ways. It drives the register port on falling system edges. It changes `oscStable` 5 ns after an oscillator edge. It runs the oscillator clock at eight system periods with a fixed 2 ns offset from the system edges. Because of this, each oscillator-edge count in R5 to R8 has one exact expected value.

// File: rtl/losc_pkg.sv
package losc_pkg;
  typedef struct packed {
    logic       wrStb;
    logic       rdStb;
    logic [3:0] laneEn;
  } regStrobe_t;

  typedef enum logic [1:0] {
    OSC_OFF   = 2'd0,
    OSC_START = 2'd1,
    OSC_ON    = 2'd2,
    OSC_STOP  = 2'd3
  } oscState_t;
endpackage

// File: rtl/losc_sync.sv
module losc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/losc_bus_ctrl.sv
module losc_bus_ctrl
  import losc_pkg::*;
#(
  parameter int WAIT_STATES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regReq,
  input  logic       regWrite,
  input  logic [3:0] regBe,
  output logic       regReady,
  output regStrobe_t strobe
);
  localparam int CW = (WAIT_STATES > 1) ? $clog2(WAIT_STATES) : 1;

  logic lastDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastDone <= 1'b0;
    else       lastDone <= regReq && regReady;
  end

  if (WAIT_STATES == 0) begin : g_nowait
    assign regReady = regReq;
  end else begin : g_wait
    logic          inWait;
    logic [CW-1:0] waitCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inWait  <= 1'b0;
        waitCnt <= '0;
      end else if (inWait) begin
        if (waitCnt == '0) inWait  <= 1'b0;
        else               waitCnt <= waitCnt - 1'b1;
      end else if (regReq && lastDone) begin
        inWait  <= 1'b1;
        waitCnt <= CW'(WAIT_STATES - 1);
      end
    end

    assign regReady = regReq && (inWait ? (waitCnt == '0) : !lastDone);

    // R9: the first cycle of a back-to-back access is always held off
    a_r9_back_to_back_held: assert property (@(posedge clk) disable iff (!rstN)
      (regReq && lastDone && !inWait) |-> !regReady);
  end

  always_comb begin
    strobe.wrStb  = regReq && regReady && regWrite;
    strobe.rdStb  = regReq && regReady && !regWrite;
    strobe.laneEn = regBe;
  end

  // R9: no completion without a request
  a_r9_ready_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    !regReq |-> !regReady);

  a_r9_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrStb, strobe.rdStb}));
endmodule

// File: rtl/losc_regs.sv
module losc_regs
  import losc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  regStrobe_t  strobe,
  input  logic [31:0] wdata,
  input  logic        readySys,
  output logic [31:0] rdata,
  output logic        enOut,
  output logic        bypassOut
);
  logic enReg;
  logic bypassReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg     <= 1'b0;
      bypassReg <= 1'b0;
    end else if (strobe.wrStb && strobe.laneEn[0]) begin
      enReg <= wdata[0];
      if (!enReg) bypassReg <= wdata[2];
    end
  end

  always_comb begin
    rdata    = '0;
    rdata[0] = enReg;
    rdata[1] = readySys;
    rdata[2] = bypassReg;
  end

  assign enOut     = enReg;
  assign bypassOut = bypassReg;

  // R4: bypass is frozen while the oscillator is enabled
  a_r4_bypass_locked: assert property (@(posedge clk) disable iff (!rstN)
    enReg |=> $stable(bypassReg));

  // R3: writes without lane 0 leave the control bits alone
  a_r3_lane_gated: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrStb && strobe.laneEn[0]) |=> ($stable(enReg) && $stable(bypassReg)));

  always_comb begin
    if (rstN) a_r3_reserved_zero: assert (rdata[31:3] == '0);
  end
endmodule

// File: rtl/losc_osc_seq.sv
module losc_osc_seq
  import losc_pkg::*;
#(
  parameter int START_CYCLES  = 64,
  parameter int BYPASS_CYCLES = 2,
  parameter int FALL_CYCLES   = 6,
  parameter int SYNC_STAGES   = 2
) (
  input  logic oscClk,
  input  logic rstN,
  input  logic enSync,
  input  logic bypassSync,
  input  logic oscStable,
  output logic readyOsc
);
  localparam int MAXC = (START_CYCLES > BYPASS_CYCLES) ?
                        ((START_CYCLES > FALL_CYCLES) ? START_CYCLES : FALL_CYCLES) :
                        ((BYPASS_CYCLES > FALL_CYCLES) ? BYPASS_CYCLES : FALL_CYCLES);
  localparam int CW        = $clog2(MAXC + 1);
  localparam int STOP_LOAD = FALL_CYCLES - SYNC_STAGES - 2;

  oscState_t     state;
  logic [CW-1:0] cnt;

  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) begin
      state <= OSC_OFF;
      cnt   <= '0;
    end else begin
      unique case (state)
        OSC_OFF: if (enSync && oscStable) begin
          state <= OSC_START;
          cnt   <= bypassSync ? CW'(BYPASS_CYCLES - 1) : CW'(START_CYCLES - 1);
        end
        OSC_START: begin
          if (!enSync) state <= OSC_OFF;
          else if (!oscStable) state <= OSC_OFF;
          else if (cnt == '0) state <= OSC_ON;
          else cnt <= cnt - 1'b1;
        end
        OSC_ON: if (!enSync) begin
          state <= OSC_STOP;
          cnt   <= CW'(STOP_LOAD);
        end
        OSC_STOP: begin
          if (enSync) state <= OSC_ON;
          else if (cnt == '0) state <= OSC_OFF;
          else cnt <= cnt - 1'b1;
        end
        default: state <= OSC_OFF;
      endcase
    end
  end

  assign readyOsc = (state == OSC_ON) || (state == OSC_STOP);

  // R5: ready only rises while enable is seen and the oscillator is stable
  a_r5_rise_enabled: assert property (@(posedge oscClk) disable iff (!rstN)
    $rose(readyOsc) |-> ($past(enSync) && $past(oscStable)));

  // R6: ready only falls after enable has been seen low
  a_r6_fall_disabled: assert property (@(posedge oscClk) disable iff (!rstN)
    $fell(readyOsc) |-> !$past(enSync));

  // R7: a re-enable seen during the countdown keeps ready high
  a_r7_abort_holds: assert property (@(posedge oscClk) disable iff (!rstN)
    (readyOsc && enSync) |=> readyOsc);
endmodule

// File: rtl/losc_ctrl.sv
module losc_ctrl
  import losc_pkg::*;
#(
  parameter int WAIT_STATES   = 2,
  parameter int START_CYCLES  = 64,
  parameter int BYPASS_CYCLES = 2,
  parameter int FALL_CYCLES   = 6,
  parameter int SYNC_STAGES   = 2
) (
  input  logic        sysClk,
  input  logic        rstN,
  input  logic        oscClk,
  input  logic        oscStable,
  input  logic        regReq,
  input  logic        regWrite,
  input  logic [3:0]  regBe,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        regReady,
  output logic        oscEn,
  output logic        oscBypass,
  output logic        oscReady
);
  regStrobe_t strobe;
  logic       readyOsc;
  logic       readySys;
  logic [1:0] ctrlOsc;

  losc_bus_ctrl #(.WAIT_STATES(WAIT_STATES)) uBus (
    .clk(sysClk), .rstN(rstN), .regReq(regReq), .regWrite(regWrite),
    .regBe(regBe), .regReady(regReady), .strobe(strobe)
  );

  losc_regs uRegs (
    .clk(sysClk), .rstN(rstN), .strobe(strobe), .wdata(regWdata),
    .readySys(readySys), .rdata(regRdata), .enOut(oscEn), .bypassOut(oscBypass)
  );

  losc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) uSyncCtrl (
    .clk(oscClk), .rstN(rstN), .din({oscBypass, oscEn}), .dout(ctrlOsc)
  );

  losc_osc_seq #(
    .START_CYCLES(START_CYCLES), .BYPASS_CYCLES(BYPASS_CYCLES),
    .FALL_CYCLES(FALL_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) uSeq (
    .oscClk(oscClk), .rstN(rstN), .enSync(ctrlOsc[0]), .bypassSync(ctrlOsc[1]),
    .oscStable(oscStable), .readyOsc(readyOsc)
  );

  losc_sync #(.WIDTH(1), .STAGES(2)) uSyncReady (
    .clk(sysClk), .rstN(rstN), .din(readyOsc), .dout(readySys)
  );

  assign oscReady = readySys;
endmodule

// File: tb/losc_ctrl_test.sv
module losc_ctrl_test;
  localparam int WS  = 2;
  localparam int STC = 8;
  localparam int BYC = 2;

  logic        sysClk = 0, oscClk = 0, rstN = 0, oscStable = 1;
  logic        regReq = 0, regWrite = 0;
  logic [3:0]  regBe = 0;
  logic [31:0] regWdata = 0, regRdata;
  logic        regReady, oscEn, oscBypass, oscReady;
  int          checks = 0, fails = 0;
  bit          done = 0;

  losc_ctrl #(.WAIT_STATES(WS), .START_CYCLES(STC), .BYPASS_CYCLES(BYC)) uut (
    .sysClk(sysClk), .rstN(rstN), .oscClk(oscClk), .oscStable(oscStable),
    .regReq(regReq), .regWrite(regWrite), .regBe(regBe), .regWdata(regWdata),
    .regRdata(regRdata), .regReady(regReady), .oscEn(oscEn),
    .oscBypass(oscBypass), .oscReady(oscReady)
  );

  always #5 sysClk = ~sysClk;
  initial begin
    #23 oscClk = 1;
    forever begin #40 oscClk = 0; #40 oscClk = 1; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic busAccess(input bit wr, input logic [3:0] be, input logic [31:0] d,
                           input bit hold, output logic [31:0] rd, output int waits);
    @(negedge sysClk);
    regReq = 1; regWrite = wr; regBe = be; regWdata = d; waits = 0;
    #1;
    while (!regReady) begin @(negedge sysClk); #1; waits++; end
    rd = regRdata;
    @(posedge sysClk);
    if (!hold) begin #1 regReq = 0; end
  endtask

  task automatic regWr(input logic [31:0] d);
    logic [31:0] rd; int w;
    busAccess(1'b1, 4'hF, d, 1'b0, rd, w);
  endtask

  task automatic regRd(output logic [31:0] rd);
    int w;
    busAccess(1'b0, 4'hF, 32'h0, 1'b0, rd, w);
  endtask

  task automatic waitOsc(input int n);
    repeat (n) @(posedge oscClk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    int w, w2;
    bit sawLow;
    #100 rstN = 1;
    repeat (3) @(negedge sysClk);

    // R1 reset state
    check(oscEn == 0, "R1 oscEn", oscEn, 0);
    check(oscBypass == 0, "R1 oscBypass", oscBypass, 0);
    check(oscReady == 0, "R1 oscReady", oscReady, 0);
    regRd(rd);
    check(rd == 0, "R1 readback", rd, 0);

    // R9 wait states: isolated then back-to-back
    repeat (3) @(negedge sysClk);
    busAccess(1'b0, 4'hF, 0, 1'b1, rd, w);
    busAccess(1'b0, 4'hF, 0, 1'b1, rd, w2);
    check(w == 0, "R9 isolated waits", w, 0);
    check(w2 == WS, "R9 back-to-back waits", w2, WS);
    busAccess(1'b0, 4'hF, 0, 1'b0, rd, w2);
    check(w2 == WS, "R9 third back-to-back waits", w2, WS);
    repeat (3) @(negedge sysClk);
    check(regReady == 0, "R9 idle ready", regReady, 0);

    // R3 lane gating, ready bit ignored, reserved bits zero
    busAccess(1'b1, 4'b1110, 32'hFFFF_FFFF, 1'b0, rd, w);
    regRd(rd);
    check(rd == 0, "R3 lane0 disabled write", rd, 0);
    regWr(32'hFFFF_FFFA);
    regRd(rd);
    check(rd == 32'h0000_0000 && oscEn == 0, "R3 bit1 and reserved ignored", rd, 0);

    // R5/R6/R10 sweep over both modes
    for (int m = 0; m < 2; m++) begin
      int n;
      n = m ? BYC : STC;
      regWr(m ? 32'h4 : 32'h0);
      check(oscBypass == m[0], "R4 bypass load while off", oscBypass, m);
      regWr(m ? 32'h5 : 32'h1);
      check(oscEn == 1, "R2 enable set", oscEn, 1);
      waitOsc(n + 2); #30;
      check(oscReady == 0, "R5 ready not yet", oscReady, 0);
      waitOsc(1); #30;
      check(oscReady == 1, "R5 ready rises", oscReady, 1);
      regRd(rd);
      check(rd == (m ? 32'h7 : 32'h3), "R10 readback on", rd, m ? 7 : 3);
      regWr(m ? 32'h4 : 32'h0);
      check(oscEn == 0, "R2 enable cleared", oscEn, 0);
      waitOsc(5); #30;
      check(oscReady == 1, "R6 ready held 5 edges", oscReady, 1);
      waitOsc(1); #30;
      check(oscReady == 0, "R6 ready falls on 6th edge", oscReady, 0);
    end

    // R4 bypass locked while enabled
    regWr(32'h0);
    check(oscBypass == 0, "R4 bypass cleared while off", oscBypass, 0);
    regWr(32'h1);
    regWr(32'h5);
    check(oscBypass == 0, "R4 bypass locked while on", oscBypass, 0);
    regWr(32'h4);
    check(oscBypass == 0 && oscEn == 0, "R4 bypass locked on disabling write", oscBypass, 0);
    regWr(32'h4);
    check(oscBypass == 1, "R4 bypass loads when off", oscBypass, 1);
    regWr(32'h0);
    waitOsc(10);

    // R7 re-enable during the fall countdown
    for (int j = 1; j <= 4; j++) begin
      regWr(32'h1);
      waitOsc(STC + 6);
      regWr(32'h0);
      waitOsc(j);
      regWr(32'h1);
      sawLow = 0;
      for (int k = 0; k < 10; k++) begin
        waitOsc(1); #30;
        if (!oscReady) sawLow = 1;
      end
      check(sawLow == (j >= 4), "R7 abort window", sawLow, j >= 4);
      regWr(32'h0);
      waitOsc(10);
    end

    // R8 stable indication gates the count
    oscStable = 0;
    regWr(32'h1);
    waitOsc(30); #30;
    check(oscReady == 0, "R8 no ready while unstable", oscReady, 0);
    @(posedge oscClk); #5 oscStable = 1;
    waitOsc(STC); #30;
    check(oscReady == 0, "R8 ready not yet after stable", oscReady, 0);
    waitOsc(1); #30;
    check(oscReady == 1, "R8 ready after stable count", oscReady, 1);

    finishRun();
  end
endmodule